// File: doc/BRIEF.md
# Storage Controller Host Command and Interrupt Section

This block is the host-facing control section of a magnetic bubble storage controller. The host writes parameter registers over a byte-wide bus. These are an enable register, a two-byte length register, a two-byte address register and a scratch byte. The host then writes a command code. The block checks each command against the enable bits. It starts an accepted command towards the transfer engine and tracks busy, completion, timing-error and error-stop status. It drives one interrupt line and a DMA request.

The transfer engine reports completion and detected errors back through three input strobes. The block decides whether an error stops the command, based on the correction-mode enables. It also raises the interrupt for the events the host has enabled. The length and address registers are split into the channel count, the 11-bit page count, the module select and the 11-bit start address. These fields drive the transfer engine directly.

Top module: `bsc_ctrl`

## Requirements
- R1: After reset, busy, interrupt, DMA request, start and abort pulses are 0, the status byte reads 0x00, and the channel, page, module and start-address outputs are 0.
- R2: A command code (wdata[3:0] written to address 0) other than abort, written while idle, sets busy, clears the op-complete, timing-error and error-stop status bits, pulses `start_o` for one cycle and presents the code on `cmd_o`, all in the cycle after the write. The status byte at address 0 is {busy, op_complete, timing_error, error_stop, 4'b0}.
- R3: The write-bootloop code 0xB written while enable bit 4 is 0 starts nothing and leaves busy at 0. It sets timing_error (status 0x20) and raises the interrupt if enable bit 1 is set.
- R4: `done_i` while busy clears busy and sets op_complete (status 0x40). The interrupt rises in the same cycle if enable bit 0 is set.
- R5: `err_i` while busy stops the command (busy 0, error_stop set, status 0x10, interrupt if enable bit 1 is set) when `uce_i` is 1 or when both correction enables (bits 2 and 3) are 0. Otherwise the command keeps running with no status change. An error stop wins over a simultaneous `done_i`.
- R6: Abort code 0x6 written while busy clears busy, pulses `abort_o` for one cycle, sets no status bit and raises no interrupt. Abort written while idle changes nothing.
- R7: Any non-abort command written while busy is ignored: no start pulse, and `cmd_o` and status are unchanged. `done_i` and `err_i` while idle are ignored.
- R8: The interrupt stays asserted until the host reads address 0, and it is 0 from the cycle after that read.
- R9: Address 4 bits [7:4] give `chan_o`. Address 4 bits [2:0] above address 3 give the 11-bit `pages_o`. Address 6 bits [7:3] give `module_o`. Address 6 bits [2:0] above address 5 give the 11-bit `start_addr_o`.
- R10: The utility register (address 2) reads back what was written and has no effect on any other output. The write-only enable register (address 1) reads 0x00. Reads have one cycle of latency.
- R11: `drq_o` is 1 in the cycle after a cycle in which busy, enable bit 5 and `xfer_need_i` are all 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe |
| addr | input | 3 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid the cycle after `rd_en` |
| done_i | input | 1 | Transfer engine reports successful completion |
| err_i | input | 1 | Transfer engine reports a detected error |
| uce_i | input | 1 | Qualifies `err_i` as uncorrectable |
| xfer_need_i | input | 1 | Data path wants a DMA transfer |
| start_o | output | 1 | One-cycle start pulse for an accepted command |
| cmd_o | output | 4 | Code of the last accepted command |
| abort_o | output | 1 | One-cycle controlled-termination pulse |
| busy_o | output | 1 | Command in progress |
| int_o | output | 1 | Host interrupt |
| drq_o | output | 1 | DMA request |
| chan_o | output | 4 | Number of channels to access |
| pages_o | output | 11 | Number of pages to transfer |
| module_o | output | 5 | Module select |
| start_addr_o | output | 11 | Starting page address within a module |

## Verification
The bench targets the write-bootloop rejection. A design that checked the wrong enable bit would start the command or lose the timing-error flag. It also targets the correction-mode qualification of errors: a wrong design would stop on a correctable error, or keep running on an uncorrectable one. Commands and abort issued at the wrong time are exercised too: a stray command while busy would relaunch `start_o`, and an abort while idle would emit `abort_o`. The interrupt must persist across idle cycles and fall only on a status read. The field slicing of the length and address bytes is checked under random values, where a shifted bit shows up as a wrong page count or module.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int DW     = 8;
  localparam int CMD_W  = 4;
  localparam int CHAN_W = 4;
  localparam int PAGE_W = 11;
  localparam int ADR_W  = 11;
  localparam int MOD_W  = 2 * DW - ADR_W;

  localparam logic [CMD_W-1:0] CMD_ABORT = 4'h6;
  localparam logic [CMD_W-1:0] CMD_WBOOT = 4'hB;

  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_ENA  = 3'd1;
  localparam logic [2:0] A_UTIL = 3'd2;
  localparam logic [2:0] A_LENL = 3'd3;
  localparam logic [2:0] A_LENH = 3'd4;
  localparam logic [2:0] A_ADRL = 3'd5;
  localparam logic [2:0] A_ADRH = 3'd6;

  typedef struct packed {
    logic [1:0] spare;
    logic       dma;
    logic       wboot;
    logic       rcd;
    logic       icd;
    logic       irq_err;
    logic       irq_done;
  } ena_t;
endpackage

// File: rtl/bsc_regs.sv
module bsc_regs
  import bsc_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output ena_t          ena,
  output logic [DW-1:0] util,
  output logic [2*DW-1:0] len_r,
  output logic [2*DW-1:0] adr_r
);
  localparam int NBYTE = 4;
  logic [DW-1:0] bytes_q [NBYTE];
  logic [AW-1:0] byte_addr [NBYTE];

  assign byte_addr[0] = AW'(A_LENL);
  assign byte_addr[1] = AW'(A_LENH);
  assign byte_addr[2] = AW'(A_ADRL);
  assign byte_addr[3] = AW'(A_ADRH);

  genvar gi;
  generate
    for (gi = 0; gi < NBYTE; gi++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) bytes_q[gi] <= '0;
        else if (wr_en && addr == byte_addr[gi]) bytes_q[gi] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ena  <= '0;
      util <= '0;
    end else if (wr_en) begin
      if (addr == AW'(A_ENA))  ena  <= ena_t'(wdata);
      if (addr == AW'(A_UTIL)) util <= wdata;
    end
  end

  assign len_r = {bytes_q[1], bytes_q[0]};
  assign adr_r = {bytes_q[3], bytes_q[2]};
endmodule

// File: rtl/bsc_seq.sv
module bsc_seq
  import bsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] code,
  input  ena_t             ena,
  input  logic             done_i,
  input  logic             err_i,
  input  logic             uce_i,
  output logic             busy,
  output logic             op_cmp,
  output logic             terr,
  output logic             estop,
  output logic             start_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             abort_o,
  output logic             ev_done,
  output logic             ev_err
);
  logic is_abort, launch, reject, stop_now, abort_now;

  assign is_abort  = (code == CMD_ABORT);
  assign launch    = cmd_wr && !busy && !is_abort;
  assign reject    = launch && (code == CMD_WBOOT) && !ena.wboot;
  assign abort_now = busy && cmd_wr && is_abort;
  assign stop_now  = busy && err_i && (uce_i || !(ena.icd || ena.rcd));

  assign ev_err  = reject || (stop_now && !abort_now);
  assign ev_done = busy && done_i && !abort_now && !stop_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      op_cmp  <= 1'b0;
      terr    <= 1'b0;
      estop   <= 1'b0;
      start_o <= 1'b0;
      abort_o <= 1'b0;
      cmd_o   <= '0;
    end else begin
      start_o <= 1'b0;
      abort_o <= 1'b0;
      if (launch) begin
        op_cmp <= 1'b0;
        estop  <= 1'b0;
        if (reject) begin
          terr <= 1'b1;
        end else begin
          terr    <= 1'b0;
          busy    <= 1'b1;
          start_o <= 1'b1;
          cmd_o   <= code;
        end
      end else if (abort_now) begin
        busy    <= 1'b0;
        abort_o <= 1'b1;
      end else if (stop_now) begin
        busy  <= 1'b0;
        estop <= 1'b1;
      end else if (ev_done) begin
        busy   <= 1'b0;
        op_cmp <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsc_irq.sv
module bsc_irq
  import bsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ena_t ena,
  input  logic ev_done,
  input  logic ev_err,
  input  logic st_rd,
  input  logic busy,
  input  logic xfer_need,
  output logic int_o,
  output logic drq_o
);
  logic raise;
  assign raise = (ev_done && ena.irq_done) || (ev_err && ena.irq_err);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_o <= 1'b0;
      drq_o <= 1'b0;
    end else begin
      int_o <= raise || (int_o && !st_rd);
      drq_o <= busy && ena.dma && xfer_need;
    end
  end
endmodule

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
  import bsc_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              uce_i,
  input  logic              xfer_need_i,
  output logic              start_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              abort_o,
  output logic              busy_o,
  output logic              int_o,
  output logic              drq_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [PAGE_W-1:0] pages_o,
  output logic [MOD_W-1:0]  module_o,
  output logic [ADR_W-1:0]  start_addr_o
);
  ena_t            ena;
  logic [DW-1:0]   util;
  logic [2*DW-1:0] len_r, adr_r;
  logic            op_cmp, terr, estop, ev_done, ev_err;
  logic            cmd_wr, st_rd;
  logic [DW-1:0]   status, rd_mux;

  assign cmd_wr = wr_en && addr == AW'(A_CMD);
  assign st_rd  = rd_en && addr == AW'(A_CMD);

  bsc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ena(ena), .util(util), .len_r(len_r), .adr_r(adr_r)
  );

  bsc_seq u_seq (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .code(wdata[CMD_W-1:0]),
    .ena(ena), .done_i(done_i), .err_i(err_i), .uce_i(uce_i),
    .busy(busy_o), .op_cmp(op_cmp), .terr(terr), .estop(estop),
    .start_o(start_o), .cmd_o(cmd_o), .abort_o(abort_o),
    .ev_done(ev_done), .ev_err(ev_err)
  );

  bsc_irq u_irq (
    .clk(clk), .rst(rst), .ena(ena), .ev_done(ev_done), .ev_err(ev_err),
    .st_rd(st_rd), .busy(busy_o), .xfer_need(xfer_need_i),
    .int_o(int_o), .drq_o(drq_o)
  );

  assign status = {busy_o, op_cmp, terr, estop, 4'b0000};

  always_comb begin
    unique case (addr)
      AW'(A_CMD):  rd_mux = status;
      AW'(A_UTIL): rd_mux = util;
      AW'(A_LENL): rd_mux = len_r[DW-1:0];
      AW'(A_LENH): rd_mux = len_r[2*DW-1:DW];
      AW'(A_ADRL): rd_mux = adr_r[DW-1:0];
      AW'(A_ADRH): rd_mux = adr_r[2*DW-1:DW];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign chan_o       = len_r[2*DW-1 -: CHAN_W];
  assign pages_o      = len_r[PAGE_W-1:0];
  assign module_o     = adr_r[2*DW-1 -: MOD_W];
  assign start_addr_o = adr_r[ADR_W-1:0];
endmodule

// File: rtl/bsc_ctrl_chk.sv
module bsc_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic start,
  input logic abort,
  input logic int_l,
  input logic drq,
  input logic st_rd,
  input logic op_cmp,
  input logic terr
);
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) start |-> busy && !$past(busy)); // R2
  AST_REJECT_NO_RUN: assert property (@(posedge clk) disable iff (rst) $rose(terr) |-> !busy && !start); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) $rose(op_cmp) |-> $past(busy) && !busy); // R4
  AST_ABORT_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) abort |-> !busy && $past(busy)); // R6
  AST_INT_STICKY: assert property (@(posedge clk) disable iff (rst) (int_l && !st_rd) |=> int_l); // R8
  AST_DRQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst) drq |-> $past(busy)); // R11
endmodule

bind bsc_ctrl bsc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy_o), .start(start_o), .abort(abort_o),
  .int_l(int_o), .drq(drq_o), .st_rd(st_rd), .op_cmp(op_cmp), .terr(terr)
);

// File: tb/bsc_ctrl_bench.sv
module bsc_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, done_i = 0, err_i = 0, uce_i = 0, xfer_need_i = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic start_o, abort_o, busy_o, int_o, drq_o;
  logic [3:0] cmd_o, chan_o;
  logic [10:0] pages_o, start_addr_o;
  logic [4:0] module_o;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bsc_ctrl u_bsc_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done_i(done_i), .err_i(err_i),
    .uce_i(uce_i), .xfer_need_i(xfer_need_i), .start_o(start_o),
    .cmd_o(cmd_o), .abort_o(abort_o), .busy_o(busy_o), .int_o(int_o),
    .drq_o(drq_o), .chan_o(chan_o), .pages_o(pages_o),
    .module_o(module_o), .start_addr_o(start_addr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic ev(input logic dn, input logic er, input logic uc);
    @(negedge clk); done_i = dn; err_i = er; uce_i = uc;
    @(negedge clk); done_i = 0; err_i = 0; uce_i = 0;
  endtask

  function automatic bit exp_stop(input logic [7:0] en, input logic uc);
    return uc || !(en[2] || en[3]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, en, ll, lh, al, ah;
    logic [3:0] code;
    int kind;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 int", int_o, 0);
    check("R1 drq", drq_o, 0);
    check("R1 start", start_o, 0);
    check("R1 fields", {chan_o, pages_o, module_o, start_addr_o}, 0);
    rd(3'd0, d); check("R1 status", d, 8'h00);

    // R10 utility readback, enable write-only
    wr(3'd2, 8'hA5); rd(3'd2, d); check("R10 util", d, 8'hA5);
    check("R10 util no effect", {busy_o, int_o, chan_o, pages_o}, 0);
    wr(3'd1, 8'h3F); rd(3'd1, d); check("R10 enable reads 0", d, 8'h00);

    // R7 commands while busy ignored, R11 drq
    wr(3'd1, 8'h21);
    wr(3'd0, 8'h02);
    check("R2 start", start_o, 1); check("R2 cmd", cmd_o, 2);
    @(negedge clk); check("R2 single pulse", start_o, 0);
    wr(3'd0, 8'h03);
    check("R7 no start when busy", start_o, 0); check("R7 cmd kept", cmd_o, 2);
    @(negedge clk); xfer_need_i = 1;
    @(negedge clk); check("R11 drq on", drq_o, 1);
    xfer_need_i = 0;
    @(negedge clk); check("R11 drq off", drq_o, 0);
    ev(1, 0, 0);
    check("R4 busy cleared", busy_o, 0); check("R4 int", int_o, 1);
    repeat (5) @(negedge clk);
    check("R8 int held", int_o, 1);
    rd(3'd0, d); check("R4 status", d, 8'h40);
    check("R8 int cleared", int_o, 0);
    // R6 abort idle ignored, R7 events while idle ignored
    wr(3'd0, 8'h06); check("R6 abort idle no pulse", abort_o, 0);
    ev(1, 1, 1);
    check("R7 idle events int", int_o, 0);
    rd(3'd0, d); check("R6 idle abort status", d, 8'h40);
    // R11 dma disabled
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); xfer_need_i = 1;
    repeat (2) @(negedge clk); check("R11 drq needs enable", drq_o, 0);
    xfer_need_i = 0;
    // R5 error stop wins over done
    wr(3'd1, 8'h02); ev(1, 1, 1);
    check("R5 stop busy", busy_o, 0); check("R5 int", int_o, 1);
    rd(3'd0, d); check("R5 stop beats done", d, 8'h10);

    // R9 random field decode
    for (int i = 0; i < 40; i++) begin
      ll = 8'($urandom); lh = 8'($urandom); al = 8'($urandom); ah = 8'($urandom);
      wr(3'd3, ll); wr(3'd4, lh); wr(3'd5, al); wr(3'd6, ah);
      check("R9 chan", chan_o, lh[7:4]);
      check("R9 pages", pages_o, {lh[2:0], ll});
      check("R9 module", module_o, ah[7:3]);
      check("R9 start", start_addr_o, {ah[2:0], al});
    end

    // R2..R6 random command sequences
    for (int i = 0; i < 150; i++) begin
      en = 8'($urandom);
      code = 4'($urandom);
      if (code == 4'h6) code = 4'h1;
      if (i % 10 == 0) code = 4'hB;
      wr(3'd1, en);
      wr(3'd0, {4'h0, code});
      if (code == 4'hB && !en[4]) begin
        check("R3 no start", start_o, 0); check("R3 idle", busy_o, 0);
        check("R3 int", int_o, en[1]);
        rd(3'd0, d); check("R3 status", d, 8'h20);
      end else begin
        check("R2 start", start_o, 1); check("R2 cmd", cmd_o, code);
        check("R2 busy", busy_o, 1);
        kind = int'($urandom % 4);
        if (kind == 0) begin
          ev(1, 0, 0);
          check("R4 busy", busy_o, 0); check("R4 int", int_o, en[0]);
          rd(3'd0, d); check("R4 status", d, 8'h40);
        end else if (kind == 3) begin
          wr(3'd0, 8'h06);
          check("R6 abort pulse", abort_o, 1); check("R6 busy", busy_o, 0);
          check("R6 no int", int_o, 0);
          rd(3'd0, d); check("R6 status", d, 8'h00);
        end else begin
          ev(0, 1, kind == 1);
          if (exp_stop(en, kind == 1)) begin
            check("R5 stop busy", busy_o, 0); check("R5 int", int_o, en[1]);
            rd(3'd0, d); check("R5 stop status", d, 8'h10);
          end else begin
            check("R5 continue", busy_o, 1); check("R5 no int", int_o, 0);
            rd(3'd0, d); check("R5 run status", d, 8'h80);
            ev(1, 0, 0);
            rd(3'd0, d); check("R4 status after ce", d, 8'h40);
          end
        end
      end
      check("R8 int cleared by read", int_o, 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule